// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between the instruction decoder and the issue stage. It accepts one decoded scalar operation that carries a vector length and a predicate mask. It then replays that operation as a run of element operations. Elements are numbered from 0 up to the vector length minus one, and they go out in strictly ascending order, exactly as if the loop had been unrolled into separate scalar instructions.

While the loop runs, the sequencer holds the program counter. It releases the counter with a single-cycle advance strobe in the same cycle that the last element group is accepted downstream. Each issue cycle carries a group of 1, 2 or 4 consecutive elements, selected per operation. Every lane in a group carries its own predicate bit. A lane whose bit is 0 is marked as masked, so downstream logic produces no result for it. Lanes that fall past the vector length in the final group are also reported as masked.

The vector length comes from a separate set-length operation, so it is an input here and not a hardware constant. A length of zero retires the operation at once and issues nothing.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset, op_ready is 1, iss_valid is 0, pc_hold is 0, pc_advance is 0 and iss_base is 0.
- R2: An operation is accepted on a clock edge where op_valid and op_ready are both 1. Its length, predicate, width and tag are captured at that edge. From then until the loop ends, op_ready is 0, pc_hold is 1, and changes on any op_* input have no effect on the issued groups.
- R3: Groups are issued in ascending element order. The first group of each operation has iss_base 0, and each accepted group that is not the last adds the group width to iss_base.
- R4: op_width selects the group width: 0 gives 1 lane, 1 gives 2 lanes, 2 gives 4 lanes, and 3 gives LANES lanes. Any selection above LANES is clamped to LANES.
- R5: Bit l of iss_mask refers to element iss_base+l. For an element inside the group width and below the vector length, that bit equals bit (iss_base+l) of the captured predicate, where 1 means execute and 0 means masked.
- R6: Lanes at or beyond the group width, and lanes whose element index is at or beyond the vector length, read 0 (masked) in iss_mask.
- R7: While iss_valid is 1 and iss_ready is 0, iss_base, iss_mask and iss_tag hold their values and the group stays offered.
- R8: pc_advance is a one-cycle pulse. It is asserted in the same cycle that the last group (iss_base + width >= length) is accepted by iss_ready. In the next cycle iss_valid is 0 and op_ready is 1.
- R9: An operation accepted with a length of 0 asserts pc_advance in its acceptance cycle and produces no issue cycle.
- R10: A length above MAXVL is treated as MAXVL.
- R11: iss_tag carries the captured op_tag unchanged on every group of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Decoded operation offered |
| op_ready | output | 1 | Sequencer idle, able to take an operation |
| op_tag | input | TAGW | Opaque decoded operation payload |
| op_vl | input | VLW | Vector length for this operation |
| op_pred | input | MAXVL | Predicate, bit e for element e |
| op_width | input | 2 | Elements per issue group selector |
| iss_valid | output | 1 | Element group offered to issue |
| iss_ready | input | 1 | Issue stage accepts the group |
| iss_base | output | VLW | Element index of lane 0 |
| iss_mask | output | LANES | Per-lane execute bit (0 = masked) |
| iss_tag | output | TAGW | Operation payload for the group |
| pc_hold | output | 1 | Program counter must stay put |
| pc_advance | output | 1 | Program counter may advance (one cycle) |

## Verification
The bound checker watches every cycle for the following properties. A stalled group must not move. Each loop must start at element 0, and consecutive groups must step by exactly the captured width. No lane past the vector length may ever be enabled. The last accepted group must return the block to idle.

Some behaviours can only be shown by the bench's scenarios, which compare the outputs against an independent model. These are the exact predicate bits per lane, the mapping from width selector to lane count, the clamping of over-long lengths, the zero-length retire, and the fact that op inputs changed mid-loop are ignored. The bench mixes directed cases with random lengths, masks, widths and back-pressure patterns. The directed cases are an 8-element loop on 4 lanes, a partial final group, zero length and an over-range length.

// File: rtl/vec_loop_seq.sv
module vec_loop_seq #(
  parameter int MAXVL = 64,
  parameter int LANES = 4,
  parameter int TAGW  = 32,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int WW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [TAGW-1:0]  op_tag,
  input  logic [VLW-1:0]   op_vl,
  input  logic [MAXVL-1:0] op_pred,
  input  logic [1:0]       op_width,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [VLW-1:0]   iss_base,
  output logic [LANES-1:0] iss_mask,
  output logic [TAGW-1:0]  iss_tag,
  output logic             pc_hold,
  output logic             pc_advance
);

  logic             busy_q;
  logic [VLW-1:0]   idx_q, vl_q, vl_in;
  logic [MAXVL-1:0] pred_q;
  logic [WW-1:0]    w_q, w_in;
  logic [TAGW-1:0]  tag_q;
  logic [LANES-1:0] pred_win;
  logic             accept, last;

  assign vl_in  = (op_vl > VLW'(MAXVL)) ? VLW'(MAXVL) : op_vl;
  assign accept = op_valid && !busy_q;

  always_comb begin
    case (op_width)
      2'd0:    w_in = WW'(1);
      2'd1:    w_in = (LANES >= 2) ? WW'(2) : WW'(LANES);
      2'd2:    w_in = (LANES >= 4) ? WW'(4) : WW'(LANES);
      default: w_in = WW'(LANES);
    endcase
  end

  assign last     = ({1'b0, idx_q} + (VLW+1)'(w_q)) >= {1'b0, vl_q};
  assign pred_win = LANES'(pred_q >> idx_q);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign iss_mask[l] = busy_q && (w_q > WW'(l)) &&
                         (({1'b0, idx_q} + (VLW+1)'(l)) < {1'b0, vl_q}) &&
                         pred_win[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
      pred_q <= '0;
      w_q    <= WW'(1);
      tag_q  <= '0;
    end else if (accept) begin
      busy_q <= (vl_in != '0);
      idx_q  <= '0;
      vl_q   <= vl_in;
      pred_q <= op_pred;
      w_q    <= w_in;
      tag_q  <= op_tag;
    end else if (busy_q && iss_ready) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + VLW'(w_q);
    end
  end

  assign op_ready   = !busy_q;
  assign iss_valid  = busy_q;
  assign iss_base   = idx_q;
  assign iss_tag    = tag_q;
  assign pc_hold    = busy_q;
  assign pc_advance = (accept && vl_in == '0) || (busy_q && iss_ready && last);

endmodule

// File: rtl/vec_loop_seq_chk.sv
module vec_loop_seq_chk #(
  parameter int MAXVL = 64,
  parameter int LANES = 4,
  parameter int TAGW  = 32,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int WW   = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [VLW-1:0]   iss_base,
  input logic [LANES-1:0] iss_mask,
  input logic [TAGW-1:0]  iss_tag,
  input logic             pc_advance,
  input logic             op_ready,
  input logic [VLW-1:0]   vl_q,
  input logic [WW-1:0]    w_q
);

  logic [LANES-1:0] in_range;
  always_comb
    for (int l = 0; l < LANES; l++)
      in_range[l] = (int'(iss_base) + l) < int'(vl_q);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_base) && $stable(iss_mask) && $stable(iss_tag));

  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iss_valid) |-> iss_base == '0);

  a_r3_step_width: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && !pc_advance |=> iss_valid && iss_base == $past(iss_base) + VLW'(w_q));

  a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && pc_advance |=> !iss_valid && op_ready);

  a_r8_adv_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && pc_advance |-> iss_ready);

  a_r6_no_lane_past_vl: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_mask & ~in_range) == '0 && iss_base < vl_q);

endmodule

bind vec_loop_seq vec_loop_seq_chk #(.MAXVL(MAXVL), .LANES(LANES), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_base(iss_base), .iss_mask(iss_mask), .iss_tag(iss_tag),
  .pc_advance(pc_advance), .op_ready(op_ready), .vl_q(vl_q), .w_q(w_q)
);

// File: tb/tb_vec_loop_seq.sv
`timescale 1ns/1ps
module tb_vec_loop_seq;
  localparam int MAXVL = 64;
  localparam int LANES = 4;
  localparam int TAGW  = 32;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_ready;
  logic [TAGW-1:0]  op_tag = '0;
  logic [VLW-1:0]   op_vl = '0;
  logic [MAXVL-1:0] op_pred = '0;
  logic [1:0]       op_width = '0;
  logic             iss_valid;
  logic             iss_ready = 1'b0;
  logic [VLW-1:0]   iss_base;
  logic [LANES-1:0] iss_mask;
  logic [TAGW-1:0]  iss_tag;
  logic             pc_hold;
  logic             pc_advance;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_loop_seq #(.MAXVL(MAXVL), .LANES(LANES), .TAGW(TAGW)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] ws);
    int w;
    w = (ws == 2'd3) ? LANES : (1 << ws);
    return (w > LANES) ? LANES : w;
  endfunction

  function automatic logic [LANES-1:0] exp_mask(input int base, input int w, input int vle,
                                                 input logic [MAXVL-1:0] pm);
    logic [LANES-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++)
      if (l < w && base + l < vle) m[l] = pm[base + l];
    return m;
  endfunction

  task automatic run_op(input int vl, input logic [MAXVL-1:0] pm, input logic [1:0] ws,
                        input logic [TAGW-1:0] tag, input bit stalls);
    int vle, w, base;
    bit rdy, last;
    vle = (vl > MAXVL) ? MAXVL : vl;
    w = width_of(ws);
    @(negedge clk);
    op_valid = 1'b1; op_vl = VLW'(vl); op_pred = pm; op_width = ws; op_tag = tag;
    iss_ready = 1'($urandom);
    #1;
    chk(op_ready == 1'b1, "R2 op_ready when idle", op_ready, 1);
    chk(pc_advance == (vle == 0), "R9 pc_advance at accept", pc_advance, vle == 0);
    @(negedge clk);
    op_valid = 1'($urandom); op_vl = VLW'($urandom); op_pred = {$urandom, $urandom};
    op_width = 2'($urandom); op_tag = $urandom;
    if (vle == 0) begin
      op_valid = 1'b0;
      #1;
      chk(iss_valid == 1'b0, "R9 no issue for zero length", iss_valid, 0);
      chk(op_ready == 1'b1, "R9 back to idle", op_ready, 1);
      return;
    end
    base = 0;
    forever begin
      rdy = stalls ? (($urandom % 3) != 0) : 1'b1;
      iss_ready = rdy;
      #1;
      last = (base + w) >= vle;
      chk(iss_valid == 1'b1, "R2 iss_valid during loop", iss_valid, 1);
      chk(pc_hold == 1'b1 && op_ready == 1'b0, "R2 hold and busy", {pc_hold, op_ready}, 2'b10);
      chk(int'(iss_base) == base, "R3 element order", iss_base, base);
      chk(iss_mask == exp_mask(base, w, vle, pm), "R5 R6 lane mask", iss_mask, exp_mask(base, w, vle, pm));
      chk(iss_tag == tag, "R11 tag pass", iss_tag, tag);
      chk(pc_advance == (rdy && last), "R8 advance pulse", pc_advance, rdy && last);
      @(negedge clk);
      op_valid = 1'($urandom); op_tag = $urandom; op_pred = {$urandom, $urandom};
      if (rdy) begin
        if (last) break;
        base += w;
      end
    end
    op_valid = 1'b0;
    iss_ready = 1'b0;
    #1;
    chk(iss_valid == 1'b0 && op_ready == 1'b1, "R8 idle after last group", {iss_valid, op_ready}, 2'b01);
    chk(pc_advance == 1'b0, "R8 single cycle pulse", pc_advance, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk(op_ready && !iss_valid && !pc_hold && !pc_advance && iss_base == '0,
        "R1 reset state", {op_ready, iss_valid, pc_hold, pc_advance}, 4'b1000);
    #10 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(op_ready && !iss_valid && !pc_hold, "R1 after reset release", {op_ready, iss_valid, pc_hold}, 3'b100);

    run_op(8, 64'h6B, 2'd2, 32'hA5A5_0001, 1'b0);   // R4 R5: groups 1011 then 0110
    run_op(5, '1, 2'd2, 32'h0000_0002, 1'b1);       // R6: partial group 0001
    run_op(0, '1, 2'd1, 32'h0000_0003, 1'b0);       // R9
    run_op(100, {$urandom, $urandom}, 2'd3, 32'h0000_0004, 1'b1); // R10 clamp to 64
    run_op(7, 64'h55, 2'd0, 32'h0000_0005, 1'b1);   // R4 single lane
    run_op(3, 64'h5, 2'd1, 32'h0000_0006, 1'b1);    // R4 two lanes
    run_op(1, 64'h0, 2'd2, 32'h0000_0007, 1'b0);    // R5 fully masked
    for (int i = 0; i < 150; i++)
      run_op($urandom % 80, {$urandom, $urandom}, 2'($urandom), $urandom, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule